// File: doc/BRIEF.md
# Interrupting Auto-Reload Interval Timer

This block is a memory-mapped countdown timer. Software writes a start value into a load register and then sets a run bit. From then on the count drops by one on every cycle in which the tick-enable input is high. When the count runs out, the block raises an interrupt request line. That line stays high until software writes to an acknowledge register. The tick-enable input comes from an external rate divider, so the divider sets the count rate. For example, a tick at 2400 per second with a load value of 24000 gives a 10-second period.

There are two ways the timer can behave on expiry. In one-shot mode it stops and clears its own run bit. In auto-restart mode it takes the load value again and keeps counting without software help, so it produces a steady stream of interrupts.

The register interface is word addressed and has a single-cycle write. Reads are combinational and reflect the register contents in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset, the run bit, the auto-restart bit, the load value and the count all read 0, and `irq` is low.
- R2: Address 0 is control, with bit 0 = run and bit 1 = auto-restart. Address 1 is the load value, of which the low `CNT_W` bits are kept and read back zero-extended. Address 2 returns the current count. Address 3 reads as 0. `rd_data` follows `addr` in the same cycle.
- R3: A control write that sets run while run is 0 copies the load value into the count. A control write with run already 1 leaves the count unchanged.
- R4: When run is 1 and `tick` is high and no control write happens in that cycle, the count decreases by one. Without a tick, or with run at 0, the count holds.
- R5: A counted tick with the count at 1 (or at 0) is an expiry. An expiry drives `irq` high from the next cycle, and `irq` stays high until it is acknowledged.
- R6: On an expiry with auto-restart at 1, the count is reloaded from the load value and run stays 1.
- R7: On an expiry with auto-restart at 0, the count becomes 0 and run clears, so bit 0 of control reads 0.
- R8: A write of any value to address 3 clears `irq` in the next cycle. If an expiry falls in the same cycle, `irq` stays high.
- R9: Writes to address 2 are ignored. A write to the load register does not change a count already in progress.
- R10: A tick that coincides with a control write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word address of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| tick | input | 1 | Count-rate enable |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
Register reads are combinational, so the bench samples `rd_data` in the same half-cycle it sets `addr`. Every write or counted tick takes effect at the one rising edge that follows it. Both the new count and the `irq` level are therefore due exactly one cycle after the stimulus.

The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then reads the result on that same falling edge, which is half a cycle after the edge that committed it. It checks the collision cases by putting both stimuli in one cycle: acknowledge together with expiry, and control write together with tick.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  output logic              irq
);
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_LOAD  = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;
  localparam logic [1:0] A_ACK   = 2'd3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run, auto_rl, pending;
  logic [CNT_W-1:0] load_val, count;

  wire ctrl_wr = wr_en && (addr == A_CTRL);
  wire load_wr = wr_en && (addr == A_LOAD);
  wire ack_wr  = wr_en && (addr == A_ACK);
  wire start   = ctrl_wr && wr_data[0] && !run;
  wire counted = run && tick && !ctrl_wr;
  wire expire  = counted && (count <= ONE);

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      auto_rl <= 1'b0;
    end else if (ctrl_wr) begin
      run     <= wr_data[0];
      auto_rl <= wr_data[1];
    end else if (expire && !auto_rl) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_val <= '0;
    else if (load_wr) load_val <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (start)   count <= load_val;
    else if (expire)  count <= auto_rl ? load_val : '0;
    else if (counted) count <= count - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (expire)  pending <= 1'b1;
    else if (ack_wr)  pending <= 1'b0;
  end

  assign irq = pending;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data[1:0] = {auto_rl, run};
      A_LOAD:  rd_data[CNT_W-1:0] = load_val;
      A_COUNT: rd_data[CNT_W-1:0] = count;
      default: rd_data = '0;
    endcase
  end

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == $past(load_val));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    counted && count > ONE |=> count == $past(count) - ONE);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || !run) && !ctrl_wr |=> $stable(count));
  assert_irq_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);
  assert_auto_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire && auto_rl |=> run && count == $past(load_val));
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !auto_rl |=> !run && count == '0);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && !expire |=> !irq);
  assert_ctrl_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !start |=> $stable(count));
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  interval_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic cycle(input logic we, input logic [1:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, '0, 1'b1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(2'd1, 32'hABCD_0005);
    rd(2'd1, v); check("R2 load readback", v, 32'd5);
    rd(2'd3, v); check("R2 ack reads zero", v, 0);
    wr(2'd2, 32'd77);
    rd(2'd2, v); check("R9 count write ignored", v, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(2'd1, 32'd3);
    wr(2'd0, 32'd1);
    rd(2'd2, v); check("R3 start loads count", v, 3);
    tk(1);
    rd(2'd2, v); check("R4 decrement", v, 2);
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R4 hold without tick", v, 2);
    tk(1);
    check("R5 no irq before zero", {31'd0, irq}, 0);
    tk(1);
    check("R5 irq on expiry", {31'd0, irq}, 1);
    rd(2'd0, v); check("R7 one-shot clears run", v, 0);
    rd(2'd2, v); check("R7 one-shot count zero", v, 0);
    tk(2);
    rd(2'd2, v); check("R4 stopped holds", v, 0);
    check("R5 irq held", {31'd0, irq}, 1);
    wr(2'd3, 32'h0);
    check("R8 ack clears irq", {31'd0, irq}, 0);
  endtask

  task automatic t_auto;
    logic [31:0] v;
    wr(2'd1, 32'd2);
    wr(2'd0, 32'd3);
    rd(2'd2, v); check("R3 start auto", v, 2);
    tk(2);
    check("R5 irq auto expiry", {31'd0, irq}, 1);
    rd(2'd2, v); check("R6 reload count", v, 2);
    rd(2'd0, v); check("R6 run kept", v, 3);
    wr(2'd1, 32'd7);
    rd(2'd2, v); check("R9 load write keeps count", v, 2);
    wr(2'd0, 32'd3);
    rd(2'd2, v); check("R3 no reload while running", v, 2);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R8 ack any value", {31'd0, irq}, 0);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(2'd1, 32'd1);
    wr(2'd0, 32'd3);
    cycle(1'b1, 2'd3, 32'd0, 1'b1);
    check("R8 expiry beats ack", {31'd0, irq}, 1);
    rd(2'd2, v); check("R6 reload in collision", v, 1);
    wr(2'd3, 32'd0);
    check("R8 later ack clears", {31'd0, irq}, 0);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_ctrl_tick;
    logic [31:0] v;
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd1);
    cycle(1'b1, 2'd0, 32'd1, 1'b1);
    rd(2'd2, v); check("R10 tick ignored on ctrl write", v, 4);
    cycle(1'b1, 2'd0, 32'd0, 1'b1);
    rd(2'd2, v); check("R10 stop write ignores tick", v, 4);
    rd(2'd0, v); check("R2 run cleared by write", v, 0);
    check("R10 no irq", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_oneshot;
    t_auto;
    t_collide;
    t_ctrl_tick;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule